// File: doc/BRIEF.md
# Serial-Loaded Mapper Configuration Register File

This block sits on a CPU write bus and builds four 5-bit configuration words from a serial stream. Each write to the upper half of the address space (address bit 15 high) carries one payload bit in data bit 0. Five such writes make a complete word, with the first bit written becoming the least significant bit. On the fifth write the assembled word goes into the register chosen by address bits 14:13 of that fifth write. The four registers are a control word, two character-bank words and a program-bank word. A separate address translator consumes them.

A write with data bit 7 set is an abort command. It empties the partial word and forces two mode bits high in the control word. A CPU read-modify-write instruction issues two writes on adjacent cycles, so the block discards any write that arrives in the cycle right after an accepted abort. A one-cycle update pulse tells the translator when a register has changed.

Top module: `sercfg_regfile`

## Requirements
- R1: After reset the control word is 0x1F, the two character-bank words and the program-bank word are 0, the update pulse is low, and the partial word is empty.
- R2: Five accepted data writes (bit 7 clear) assemble a word LSB first: the data bit 0 of the k-th write (k = 0..4) becomes bit k of the word. Data bits 6:1 have no effect.
- R3: The fifth write stores the word into the register selected by its own address bits 14:13 (0 control, 1 character bank low, 2 character bank high, 3 program bank). The other three registers keep their values, and the selection on the first four writes does not matter.
- R4: The first four data writes of a sequence change no register.
- R5: An accepted write with data bit 7 set discards any partial word, so the next five data writes form a fresh word. It sets control bits 3:2 to 1, keeps control bits 4, 1 and 0, and leaves the other three registers unchanged.
- R6: Any write in the clock cycle directly after an accepted abort write is ignored entirely, whether it is a data write or another abort. A write two or more cycles after the abort is accepted. The guard is not active after reset.
- R7: A cycle with the write strobe low, or with address bit 15 low, changes neither the registers nor the partial word.
- R8: The update pulse is high for exactly the one cycle after a register commit or an accepted abort write, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | Write cycle strobe |
| cpuA15 | input | 1 | Address bit 15; high marks the register window |
| selAddr | input | 2 | Address bits 14:13, register select |
| wrData | input | 8 | Write data; bit 0 is payload, bit 7 is abort |
| ctrlReg | output | 5 | Control word |
| chrLoReg | output | 5 | Character bank word, low half |
| chrHiReg | output | 5 | Character bank word, high half |
| prgReg | output | 5 | Program bank word |
| updPulse | output | 1 | One-cycle notice that a register changed |

## Verification
The assertions check the following on every cycle: registers hold during idle or out-of-window cycles, at most one register changes per cycle, control bits 3:2 are set after any abort, and the update pulse appears only after a bus write and never after an abort that fell inside the guard window. Only the bench scenarios can show that the value stored matches the bit order. The same holds for a mid-sequence abort, which must really restart the count, and for a dropped write after an abort, which must not advance the bit position. For these the bench compares every cycle against an independent model of the serial protocol.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int REG_W    = 5;
  localparam int SEL_W    = 2;
  localparam int NUM_REGS = 1 << SEL_W;

  // strobes from sequencing control to the register datapath
  typedef struct packed {
    logic             shiftEn;    // store payload bit at current position
    logic             clearSeq;   // empty partial word
    logic             forceCtrl;  // OR mode bits into control word
    logic             commit;     // write assembled word to selected register
    logic [SEL_W-1:0] commitSel;
  } seqStrobe_t;
endpackage

// File: rtl/sercfg_ctrl.sv
module sercfg_ctrl
  import sercfg_pkg::*;
#(
  parameter int GUARD_CYC = 2,
  parameter int IDX_W     = $clog2(REG_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStb,
  input  logic             cpuA15,
  input  logic [SEL_W-1:0] selAddr,
  input  logic             abortBit,
  output seqStrobe_t       strb,
  output logic [IDX_W-1:0] bitIdx,
  output logic             updPulse
);
  localparam int GCW = $clog2(GUARD_CYC + 1);
  localparam logic [GCW-1:0] GUARD_SAT = GCW'(GUARD_CYC - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REG_W - 1);

  logic [GCW-1:0] sinceRst;
  logic blocked, accepted, isAbort, isData, lastBit;

  assign blocked  = (sinceRst < GUARD_SAT);
  assign accepted = wrStb & cpuA15 & ~blocked;
  assign isAbort  = accepted & abortBit;
  assign isData   = accepted & ~abortBit;
  assign lastBit  = (bitIdx == LAST_IDX);

  always_comb begin
    strb.shiftEn   = isData & ~lastBit;
    strb.commit    = isData & lastBit;
    strb.clearSeq  = isAbort | (isData & lastBit);
    strb.forceCtrl = isAbort;
    strb.commitSel = selAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx <= '0;
    end else if (strb.clearSeq) begin
      bitIdx <= '0;
    end else if (strb.shiftEn) begin
      bitIdx <= bitIdx + 1'b1;
    end
  end

  // cycles elapsed since last accepted abort, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceRst <= GUARD_SAT;
    end else if (isAbort) begin
      sinceRst <= '0;
    end else if (sinceRst < GUARD_SAT) begin
      sinceRst <= sinceRst + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) updPulse <= 1'b0;
    else       updPulse <= strb.commit | strb.forceCtrl;
  end
endmodule

// File: rtl/sercfg_dpath.sv
module sercfg_dpath
  import sercfg_pkg::*;
#(
  parameter logic [REG_W-1:0] CTRL_INIT  = 5'h1F,
  parameter logic [REG_W-1:0] CTRL_FORCE = 5'h0C,
  parameter int               IDX_W      = $clog2(REG_W)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  seqStrobe_t                        strb,
  input  logic [IDX_W-1:0]                  bitIdx,
  input  logic                              dataBit,
  output logic [NUM_REGS-1:0][REG_W-1:0]    cfgRegs
);
  localparam int BUF_W = REG_W - 1;

  logic [BUF_W-1:0] shiftBuf;
  logic [REG_W-1:0] assembled;

  genvar i;
  generate
    for (i = 0; i < BUF_W; i++) begin : g_buf
      always_ff @(posedge clk) begin
        if (!rstN) begin
          shiftBuf[i] <= 1'b0;
        end else if (strb.clearSeq) begin
          shiftBuf[i] <= 1'b0;
        end else if (strb.shiftEn && bitIdx == IDX_W'(i)) begin
          shiftBuf[i] <= dataBit;
        end
      end
    end
  endgenerate

  // final bit goes straight into the MSB of the committed word
  assign assembled = {dataBit, shiftBuf};

  genvar r;
  generate
    for (r = 0; r < NUM_REGS; r++) begin : g_reg
      logic hit;
      assign hit = strb.commit && (strb.commitSel == SEL_W'(r));
      if (r == 0) begin : g_ctrl
        always_ff @(posedge clk) begin
          if (!rstN)               cfgRegs[r] <= CTRL_INIT;
          else if (hit)            cfgRegs[r] <= assembled;
          else if (strb.forceCtrl) cfgRegs[r] <= cfgRegs[r] | CTRL_FORCE;
        end
      end else begin : g_bank
        always_ff @(posedge clk) begin
          if (!rstN)    cfgRegs[r] <= '0;
          else if (hit) cfgRegs[r] <= assembled;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/sercfg_regfile.sv
module sercfg_regfile
  import sercfg_pkg::*;
#(
  parameter int               DATA_W     = 8,
  parameter int               ABORT_BIT  = 7,
  parameter int               GUARD_CYC  = 2,
  parameter logic [REG_W-1:0] CTRL_INIT  = 5'h1F,
  parameter logic [REG_W-1:0] CTRL_FORCE = 5'h0C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic              cpuA15,
  input  logic [SEL_W-1:0]  selAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [REG_W-1:0]  ctrlReg,
  output logic [REG_W-1:0]  chrLoReg,
  output logic [REG_W-1:0]  chrHiReg,
  output logic [REG_W-1:0]  prgReg,
  output logic              updPulse
);
  localparam int IDX_W = $clog2(REG_W);

  seqStrobe_t                     strb;
  logic [IDX_W-1:0]               bitIdx;
  logic [NUM_REGS-1:0][REG_W-1:0] cfgRegs;
  logic                           unusedDataBits;

  assign unusedDataBits = ^wrData;

  sercfg_ctrl #(.GUARD_CYC(GUARD_CYC), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrStb    (wrStb),
    .cpuA15   (cpuA15),
    .selAddr  (selAddr),
    .abortBit (wrData[ABORT_BIT]),
    .strb     (strb),
    .bitIdx   (bitIdx),
    .updPulse (updPulse)
  );

  sercfg_dpath #(.CTRL_INIT(CTRL_INIT), .CTRL_FORCE(CTRL_FORCE), .IDX_W(IDX_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .bitIdx  (bitIdx),
    .dataBit (wrData[0]),
    .cfgRegs (cfgRegs)
  );

  assign ctrlReg  = cfgRegs[0];
  assign chrLoReg = cfgRegs[1];
  assign chrHiReg = cfgRegs[2];
  assign prgReg   = cfgRegs[3];
endmodule

// File: rtl/sercfg_chk.sv
module sercfg_chk #(
  parameter int         ABORT_BIT  = 7,
  parameter logic [4:0] CTRL_FORCE = 5'h0C
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrStb,
  input logic       cpuA15,
  input logic [7:0] wrData,
  input logic [4:0] ctrlReg,
  input logic [4:0] chrLoReg,
  input logic [4:0] chrHiReg,
  input logic [4:0] prgReg,
  input logic       updPulse
);
  logic busWr, abortWr;
  logic [19:0] allRegs;
  assign busWr   = wrStb & cpuA15;
  assign abortWr = busWr & wrData[ABORT_BIT];
  assign allRegs = {ctrlReg, chrLoReg, chrHiReg, prgReg};

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |=> $stable(allRegs));

  // R8
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    updPulse |-> $past(busWr));

  // R8
  quiet_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |=> !updPulse);

  // R5
  abort_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortWr |=> ((ctrlReg & CTRL_FORCE) == CTRL_FORCE));

  // R3
  single_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({!$stable(ctrlReg), !$stable(chrLoReg),
                !$stable(chrHiReg), !$stable(prgReg)}) <= 1);

  // R6
  guard_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(abortWr) && abortWr && !$past(abortWr, 2)) |=> !updPulse);
endmodule

bind sercfg_regfile sercfg_chk #(.ABORT_BIT(ABORT_BIT), .CTRL_FORCE(CTRL_FORCE)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrStb    (wrStb),
  .cpuA15   (cpuA15),
  .wrData   (wrData),
  .ctrlReg  (ctrlReg),
  .chrLoReg (chrLoReg),
  .chrHiReg (chrHiReg),
  .prgReg   (prgReg),
  .updPulse (updPulse)
);

// File: tb/test_sercfg_regfile.sv
module test_sercfg_regfile;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStb = 1'b0;
  logic       cpuA15 = 1'b0;
  logic [1:0] selAddr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [4:0] ctrlReg, chrLoReg, chrHiReg, prgReg;
  logic       updPulse;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sercfg_regfile i_sercfg_regfile (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .cpuA15(cpuA15), .selAddr(selAddr),
    .wrData(wrData), .ctrlReg(ctrlReg), .chrLoReg(chrLoReg), .chrHiReg(chrHiReg),
    .prgReg(prgReg), .updPulse(updPulse)
  );

  typedef struct {
    logic [4:0] regs[4];
    logic       pulse;
    string      tag;
  } exp_t;

  exp_t expQ[$];
  int   nChecks = 0;
  int   nFails  = 0;
  bit   done    = 0;

  // reference model of the serial protocol
  logic [4:0] mRegs[4];
  logic [4:0] mBuf;
  int         mCnt;
  bit         mPrevRst;

  task automatic drive(input logic en, input logic a15, input logic [1:0] sel,
                       input logic [7:0] d, input string tag);
    exp_t e;
    bit   acc;
    bit   nextPrev;
    @(negedge clk);
    wrStb = en; cpuA15 = a15; selAddr = sel; wrData = d;
    acc = en && a15 && !mPrevRst;   // R6 guard in model
    nextPrev = 0;
    e.pulse = 1'b0;
    if (acc) begin
      if (d[7]) begin
        mBuf = '0; mCnt = 0;
        mRegs[0] = mRegs[0] | 5'h0C;
        e.pulse = 1'b1;
        nextPrev = 1;
      end else begin
        mBuf[mCnt] = d[0];
        mCnt++;
        if (mCnt == 5) begin
          mRegs[sel] = mBuf;
          mBuf = '0; mCnt = 0;
          e.pulse = 1'b1;
        end
      end
    end
    mPrevRst = nextPrev;
    for (int k = 0; k < 4; k++) e.regs[k] = mRegs[k];
    e.tag = tag;
    @(posedge clk);
    expQ.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 1'b0, 2'd0, 8'h00, tag);
  endtask

  // five writes, LSB first, with noise in bits 6:1
  task automatic loadWord(input logic [1:0] sel, input logic [4:0] val, input string tag);
    for (int k = 0; k < 5; k++)
      drive(1'b1, 1'b1, sel, {1'b0, 6'(6'h2B ^ (k * 7)), val[k]}, tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      logic [4:0] got[4];
      e = expQ.pop_front();
      got[0] = ctrlReg; got[1] = chrLoReg; got[2] = chrHiReg; got[3] = prgReg;
      nChecks++;
      if (got != e.regs || updPulse !== e.pulse) begin
        nFails++;
        $display("FAIL %s: got ctrl=%h lo=%h hi=%h prg=%h pulse=%b, expected ctrl=%h lo=%h hi=%h prg=%h pulse=%b (R8 pulse)",
                 e.tag, ctrlReg, chrLoReg, chrHiReg, prgReg, updPulse,
                 e.regs[0], e.regs[1], e.regs[2], e.regs[3], e.pulse);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    mRegs[0] = 5'h1F; mRegs[1] = 0; mRegs[2] = 0; mRegs[3] = 0;
    mBuf = 0; mCnt = 0; mPrevRst = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    @(negedge clk);
    nChecks++;
    if (ctrlReg !== 5'h1F || chrLoReg !== 0 || chrHiReg !== 0 || prgReg !== 0 || updPulse !== 0) begin
      nFails++;
      $display("FAIL R1: got %h %h %h %h %b, expected 1f 00 00 00 0",
               ctrlReg, chrLoReg, chrHiReg, prgReg, updPulse);
    end

    // R2/R4 LSB-first assembly into program bank
    loadWord(2'd3, 5'b01101, "R2/R4");
    idle("R8");
    // R3 every select value
    loadWord(2'd1, 5'h12, "R3");
    loadWord(2'd2, 5'h07, "R3");
    loadWord(2'd0, 5'h02, "R3");
    idle("R8");
    // R5 abort sets control mode bits
    drive(1'b1, 1'b1, 2'd1, 8'h80, "R5");
    idle("R5");
    // R5 abort in mid-sequence restarts the count
    drive(1'b1, 1'b1, 2'd3, 8'h01, "R5");
    drive(1'b1, 1'b1, 2'd3, 8'h01, "R5");
    drive(1'b1, 1'b1, 2'd3, 8'h01, "R5");
    idle("R5");
    drive(1'b1, 1'b1, 2'd3, 8'hFE, "R5");
    idle("R5");
    loadWord(2'd3, 5'h10, "R5");
    // R6 back-to-back: second write dropped
    drive(1'b1, 1'b1, 2'd2, 8'h80, "R6");
    drive(1'b1, 1'b1, 2'd2, 8'h01, "R6");
    loadWord(2'd2, 5'h15, "R6");
    drive(1'b1, 1'b1, 2'd0, 8'h80, "R6");
    drive(1'b1, 1'b1, 2'd0, 8'h80, "R6");
    idle("R6");
    drive(1'b1, 1'b1, 2'd0, 8'h80, "R6");
    idle("R6");
    drive(1'b1, 1'b1, 2'd1, 8'h01, "R6");
    drive(1'b1, 1'b1, 2'd1, 8'h00, "R6");
    drive(1'b1, 1'b1, 2'd1, 8'h01, "R6");
    drive(1'b1, 1'b1, 2'd1, 8'h01, "R6");
    drive(1'b1, 1'b1, 2'd1, 8'h00, "R6");
    // R7 strobe low or A15 low ignored mid-sequence
    drive(1'b1, 1'b1, 2'd1, 8'h01, "R7");
    drive(1'b1, 1'b1, 2'd1, 8'h00, "R7");
    drive(1'b0, 1'b1, 2'd1, 8'h01, "R7");
    drive(1'b1, 1'b0, 2'd1, 8'h01, "R7");
    drive(1'b1, 1'b0, 2'd1, 8'h80, "R7");
    drive(1'b1, 1'b1, 2'd1, 8'h01, "R7");
    drive(1'b1, 1'b1, 2'd1, 8'h01, "R7");
    drive(1'b1, 1'b1, 2'd1, 8'h00, "R7");
    // R3 fifth write's select wins
    drive(1'b1, 1'b1, 2'd0, 8'h01, "R3");
    drive(1'b1, 1'b1, 2'd0, 8'h01, "R3");
    drive(1'b1, 1'b1, 2'd0, 8'h00, "R3");
    drive(1'b1, 1'b1, 2'd0, 8'h00, "R3");
    drive(1'b1, 1'b1, 2'd2, 8'h01, "R3");
    idle("R8");
    idle("R8");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule